// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple memory-mapped register bus with APB-style setup and access phases. Once software enables it, a stage counter counts ticks for a programmable interrupt interval. When that interval ends, the block latches an interrupt status bit. If the reset stage is enabled, a second counting stage then starts, and when it ends a system reset output rises and stays high until the block itself is reset. Software keeps the block from firing by writing a restart key, which returns it to the start of the interrupt stage.

Every write to the control or restart register must directly follow an unlock write that carries a 16-bit key. The unlock covers exactly one later write. Ticks come from one of two sources: every bus clock, or the rising edges of a slow external clock-enable input, which is synchronized into the bus clock domain first. The parameter `SCALE_SHIFT` divides every interval by a power of two so the block can run faster. The default value of 0 gives the full intervals.

Top module: `wdt_twostage`

## Requirements
- R1: After reset, the control register reads 0, the unlock state reads 0, the interrupt status is 0, and both `irq` and `sys_rst` are low.
- R2: Writing 0x5AA5 to the low 16 bits at offset 0x18 sets the unlock state, which reads back on bit 0 at that offset. Writing any other value to offset 0x18 clears the unlock state.
- R3: A write to the control register (0x10) or to the restart register (0x14) while the unlock state is clear has no effect.
- R4: Any completed write to an offset other than 0x18 clears the unlock state after that write, and the write itself is applied if the block was unlocked.
- R5: Control bits at 0x10, read back unchanged in bits 9:0:
  - bit 0: enable
  - bit 1: tick source (1 = every bus clock)
  - bit 2: interrupt enable
  - bit 3: reset-stage enable
  - bits 7:4: interrupt interval code
  - bits 9:8: reset interval code
- R6: Interrupt interval codes 0 to 7 give 64, 256, 1024, 2048, 4096, 8192, 16384 and 32768 ticks. Each count is divided by 2^SCALE_SHIFT. Codes 8 to 15 act as code 7. The status bit is set exactly that many ticks after the enabling control write.
- R7: Reset interval codes 0 to 3 give 128, 256, 512 and 1024 ticks, each divided by 2^SCALE_SHIFT. The reset stage starts only when the interrupt stage ends with reset enabled. `sys_rst` rises after the interval, and once high it stays high until `rst_n` is asserted.
- R8: One unlocked control write that sets enable, interrupt enable, reset enable, interrupt code 7 and reset code 0 produces the interrupt and then the reset, with no further writes.
- R9: An unlocked write of 0x3C96 to offset 0x14 clears the stage counter and restarts the interrupt stage.
- R10: Bit 0 at offset 0x1C is set when the interrupt stage ends, and writing 1 to it clears it. `irq` equals this bit ANDed with the interrupt enable.
- R11: When control bit 1 is 0, each rising edge of `tick_ext` counts as one tick, seen after the synchronizer, and bus clocks do not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, combinational on `paddr` |
| tick_ext | input | 1 | Slow external clock-enable |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with `SCALE_SHIFT` = 4 and two synchronizer stages. With that scaling, the longest interrupt interval takes 2048 cycles and the shortest takes 4, so every interval code and every reset code, including the reserved interrupt codes, can be timed to the exact cycle in one run. The short intervals also make the external tick path, where a few pulses complete a stage, practical to check alongside the cycle-exact restart and unlock tests.

// File: rtl/wdt2s_pkg.sv
package wdt2s_pkg;

   localparam int OFS_CTRL  = 'h10;
   localparam int OFS_RSTRT = 'h14;
   localparam int OFS_UNLK  = 'h18;
   localparam int OFS_STAT  = 'h1C;

   localparam logic [15:0] UNLOCK_KEY  = 16'h5AA5;
   localparam logic [15:0] RESTART_KEY = 16'h3C96;

   localparam int CTRL_W = 10;

   typedef enum logic [1:0] {ST_INT, ST_RST, ST_DONE} stage_e;

   // packed MSB first so that the layout matches control bits 9:0
   typedef struct packed {
      logic [1:0] rst_code;
      logic [3:0] int_code;
      logic       rst_en;
      logic       int_en;
      logic       bus_tick;
      logic       en;
   } ctrl_t;

endpackage

// File: rtl/wdt2s_tick.sv
module wdt2s_tick #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_ce,
   input  logic bus_sel,
   output logic tick
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= ext_ce;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign tick = bus_sel | (sync_q[SYNC_STAGES-1] & ~prev_q);

endmodule

// File: rtl/wdt2s_timer.sv
module wdt2s_timer
   import wdt2s_pkg::*;
#(
   parameter int SCALE_SHIFT = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       restart,
   input  logic       rst_en,
   input  logic [3:0] int_code,
   input  logic [1:0] rst_code,
   output logic       int_exp,
   output logic       sys_rst
);

   localparam int CNT_W = 16 - SCALE_SHIFT;

   stage_e           stage_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [CNT_W-1:0] int_last(input logic [3:0] c);
      int e;
      if (c == 4'd0)      e = 6;
      else if (c == 4'd1) e = 8;
      else if (c < 4'd8)  e = int'(c) + 8;
      else                e = 15;
      return CNT_W'((32'd1 << (e - SCALE_SHIFT)) - 32'd1);
   endfunction

   function automatic logic [CNT_W-1:0] rst_last(input logic [1:0] c);
      int e;
      e = 7 + int'(c);
      return CNT_W'((32'd1 << (e - SCALE_SHIFT)) - 32'd1);
   endfunction

   logic adv;
   assign adv     = en & ~restart & tick;
   assign int_exp = adv & (stage_q == ST_INT) & (cnt_q == int_last(int_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= ST_INT;
         cnt_q   <= '0;
         sys_rst <= 1'b0;
      end else if (!en || restart) begin
         stage_q <= ST_INT;
         cnt_q   <= '0;
      end else if (tick) begin
         case (stage_q)
            ST_INT: begin
               if (int_exp) begin
                  cnt_q   <= '0;
                  stage_q <= rst_en ? ST_RST : ST_DONE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RST: begin
               if (!rst_en) begin
                  stage_q <= ST_DONE;
               end else if (cnt_q == rst_last(rst_code)) begin
                  sys_rst <= 1'b1;
                  stage_q <= ST_DONE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/wdt2s_regs.sv
module wdt2s_regs
   import wdt2s_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              int_exp,
   output ctrl_t             ctrl,
   output logic              unlocked,
   output logic              status,
   output logic              restart
);

   logic wr;
   logic hit_ctrl, hit_rstrt, hit_unlk, hit_stat;

   assign wr        = psel & penable & pwrite;
   assign hit_ctrl  = (paddr == ADDR_W'(OFS_CTRL));
   assign hit_rstrt = (paddr == ADDR_W'(OFS_RSTRT));
   assign hit_unlk  = (paddr == ADDR_W'(OFS_UNLK));
   assign hit_stat  = (paddr == ADDR_W'(OFS_STAT));

   assign restart = wr & hit_rstrt & unlocked & (pwdata[15:0] == RESTART_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         unlocked <= 1'b0;
      end else if (wr) begin
         if (hit_unlk) begin
            unlocked <= (pwdata[15:0] == UNLOCK_KEY);
         end else begin
            unlocked <= 1'b0;
            if (hit_ctrl && unlocked) ctrl <= ctrl_t'(pwdata[CTRL_W-1:0]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          status <= 1'b0;
      else if (int_exp)                    status <= 1'b1;
      else if (wr && hit_stat && pwdata[0]) status <= 1'b0;
   end

   always_comb begin
      prdata = '0;
      if (hit_ctrl)      prdata = DATA_W'(ctrl);
      else if (hit_unlk) prdata = DATA_W'(unlocked);
      else if (hit_stat) prdata = DATA_W'(status);
   end

endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
   import wdt2s_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int SCALE_SHIFT = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              tick_ext,
   output logic              irq,
   output logic              sys_rst
);

   initial begin
      if (ADDR_W < 5)                         $error("ADDR_W must reach offset 0x1C");
      if (DATA_W < 16)                        $error("DATA_W must hold a 16-bit key");
      if (SCALE_SHIFT < 0 || SCALE_SHIFT > 6) $error("SCALE_SHIFT out of range 0..6");
      if (SYNC_STAGES < 2)                    $error("SYNC_STAGES must be at least 2");
   end

   ctrl_t ctrl;
   logic  unlocked, status, restart, int_exp, tick;

   wdt2s_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .int_exp(int_exp),
      .ctrl(ctrl), .unlocked(unlocked), .status(status), .restart(restart)
   );

   wdt2s_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .ext_ce(tick_ext), .bus_sel(ctrl.bus_tick), .tick(tick)
   );

   wdt2s_timer #(.SCALE_SHIFT(SCALE_SHIFT)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .tick(tick), .restart(restart),
      .rst_en(ctrl.rst_en), .int_code(ctrl.int_code), .rst_code(ctrl.rst_code),
      .int_exp(int_exp), .sys_rst(sys_rst)
   );

   assign irq = status & ctrl.int_en;

endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk
   import wdt2s_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr,
   input logic [ADDR_W-1:0] paddr,
   input logic              wbit0,
   input ctrl_t             ctrl,
   input logic              unlocked,
   input logic              status,
   input logic              int_exp,
   input logic              irq,
   input logic              sys_rst
);

   // R3
   a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == ADDR_W'(OFS_CTRL) && !unlocked) |=> $stable(ctrl));

   // R4
   a_r4_unlock_spent: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr != ADDR_W'(OFS_UNLK)) |=> !unlocked);

   // R7
   a_r7_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> sys_rst);

   // R7
   a_r7_rst_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(ctrl.rst_en));

   // R10
   a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == ADDR_W'(OFS_STAT) && wbit0 && !int_exp) |=> !status);

   // R10
   a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl.int_en && status));

endmodule

bind wdt_twostage wdt_twostage_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr(psel & penable & pwrite), .paddr(paddr),
   .wbit0(pwdata[0]), .ctrl(ctrl), .unlocked(unlocked), .status(status),
   .int_exp(int_exp), .irq(irq), .sys_rst(sys_rst)
);

// File: tb/wdt_twostage_tb.sv
module wdt_twostage_tb;

   localparam int AW = 5;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0;
   logic [DW-1:0] prdata;
   logic          tick_ext = 1'b0;
   logic          irq, sys_rst;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wdt_twostage #(.ADDR_W(AW), .DATA_W(DW), .SCALE_SHIFT(4), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick_ext(tick_ext),
      .irq(irq), .sys_rst(sys_rst)
   );

   // interval table, scaled by 2^4: int code, rst code, ticks to irq, ticks irq->reset
   localparam int NV = 6;
   localparam int V_IC [NV] = '{0, 1, 2, 3, 7, 9};
   localparam int V_RC [NV] = '{0, 1, 2, 3, 0, 3};
   localparam int V_NI [NV] = '{4, 16, 64, 128, 2048, 2048};
   localparam int V_NR [NV] = '{8, 16, 32, 64, 8, 64};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a negedge; the write commits at the second posedge; returns at the next negedge
   task automatic bus_wr(input int a, input logic [31:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = AW'(a); pwdata = d; penable = 1'b0;
      @(negedge clk); penable = 1'b1;
      @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      psel = 1'b1; pwrite = 1'b0; paddr = AW'(a);
      #1 d = prdata;
      psel = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ctrl_wr(input logic [31:0] d);
      bus_wr('h18, 32'h5AA5);
      bus_wr('h10, d);
   endtask

   // negedges until sig is high, counted from the current negedge
   task automatic wait_hi(input bit which_rst, input int lim, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (((which_rst ? sys_rst : irq) !== 1'b1) && n < lim);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int n;
      @(negedge clk);
      do_reset();

      // R1
      bus_rd('h10, rd); chk("R1 ctrl", rd, 0);
      bus_rd('h18, rd); chk("R1 unlock", rd, 0);
      bus_rd('h1C, rd); chk("R1 status", rd, 0);
      chk("R1 outputs", {30'd0, irq, sys_rst}, 0);

      // R3: locked control write ignored
      bus_wr('h10, 32'h0F);
      bus_rd('h10, rd); chk("R3 locked ctrl", rd, 0);

      // R2: key unlocks, other value relocks
      bus_wr('h18, 32'h5AA5);
      bus_rd('h18, rd); chk("R2 unlock set", rd, 1);
      bus_wr('h18, 32'h1234);
      bus_rd('h18, rd); chk("R2 bad key", rd, 0);
      bus_wr('h10, 32'h0F);
      bus_rd('h10, rd); chk("R2 relocked ctrl", rd, 0);

      // R4 and R5: one write per unlock, fields read back
      ctrl_wr(32'h2A4);
      bus_rd('h10, rd); chk("R5 ctrl readback", rd, 32'h2A4);
      bus_rd('h18, rd); chk("R4 unlock spent", rd, 0);
      bus_wr('h10, 32'h155);
      bus_rd('h10, rd); chk("R4 second write ignored", rd, 32'h2A4);

      // R6 R7 R8: interval table, each run from reset
      for (int i = 0; i < NV; i++) begin
         do_reset();
         ctrl_wr(32'((V_RC[i] << 8) | (V_IC[i] << 4) | 'hF));
         wait_hi(1'b0, 5000, n);
         chk($sformatf("R6 int code %0d", V_IC[i]), n, V_NI[i]);
         wait_hi(1'b1, 5000, n);
         chk($sformatf("R7 rst code %0d (R8 when 7/0)", V_RC[i]), n, V_NR[i]);
      end

      // R7: reset held until rst_n
      repeat (20) @(negedge clk);
      chk("R7 sticky", sys_rst, 1);
      do_reset();
      chk("R7 cleared by rst_n", sys_rst, 0);

      // R7: no reset stage when disabled
      ctrl_wr(32'h007);
      wait_hi(1'b0, 100, n);
      repeat (300) @(negedge clk);
      chk("R7 rst disabled", {irq, sys_rst}, 2'b10);

      // R10: W1C
      bus_wr('h1C, 32'h1);
      chk("R10 irq after clear", irq, 0);
      bus_rd('h1C, rd); chk("R10 status cleared", rd, 0);

      // R10: interrupt gated by enable
      do_reset();
      ctrl_wr(32'h003);
      repeat (10) @(negedge clk);
      chk("R10 irq gated", irq, 0);
      bus_rd('h1C, rd); chk("R10 status set", rd, 1);

      // R3 R9: locked restart ignored, unlocked restart restarts
      do_reset();
      ctrl_wr(32'h027);
      bus_wr('h14, 32'h3C96);
      wait_hi(1'b0, 500, n);
      chk("R3 locked restart", n, 62);
      do_reset();
      ctrl_wr(32'h027);
      repeat (30) @(negedge clk);
      bus_wr('h18, 32'h5AA5);
      bus_wr('h14, 32'h3C96);
      wait_hi(1'b0, 500, n);
      chk("R9 restart", n, 64);

      // R11: external ticks
      do_reset();
      ctrl_wr(32'h005);
      for (int p = 0; p < 3; p++) begin
         tick_ext = 1'b1; repeat (3) @(negedge clk);
         tick_ext = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk("R11 three ext ticks", irq, 0);
      tick_ext = 1'b1; repeat (3) @(negedge clk);
      tick_ext = 1'b0; repeat (3) @(negedge clk);
      chk("R11 fourth ext tick", irq, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule